// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit Accumulator CPU

This block resolves the operand of one instruction for an 8-bit accumulator CPU with a 16-bit address space. The decoder presents an addressing-mode code, the one or two bytes that follow the opcode, and the current X and Y index values, with a one-cycle request strobe. The block classifies the operand and returns the result with a one-cycle done pulse. The result is one of four kinds: no operand, an immediate byte, a signed branch offset, or a 16-bit effective address.

Modes that need no memory access finish in the cycle after the request. The three pointer modes take a small sequencer. It issues two single-byte reads on a memory read port with one cycle of latency: the pointer's low byte, then its high byte. It then forms the address. Reading the operand itself and taking branches belong to the stages downstream.

Top module: `ea_gen`

## Requirements
- R1: While rst_ni is low, and at the first sample after it rises, busy_o, done_o and rd_en_o are 0.
- R2: Mode codes 0 and 1 (accumulator, implied) and the unused codes 13 to 15 complete with kind_o = 0 (none), value_o = 0 and addr_o = 0.
- R3: Mode 2 (immediate) completes with kind_o = 1 and value_o = op_lo_i. addr_o is 0.
- R4: Mode 6 (relative) completes with kind_o = 2 and value_o = op_lo_i, to be read as a two's-complement offset. addr_o is 0.
- R5: Mode 3 gives addr_o = {8'h00, op_lo_i}. Modes 4 and 5 give {8'h00, (op_lo_i + x_i) mod 256} and {8'h00, (op_lo_i + y_i) mod 256}. All three return kind_o = 3 and value_o = 0.
- R6: Mode 7 gives addr_o = {op_hi_i, op_lo_i}. Modes 8 and 9 add the zero-extended x_i or y_i to that value modulo 65536. All three return kind_o = 3.
- R7: Mode 10 (indirect) reads the byte at P = {op_hi_i, op_lo_i} and then the byte at (P+1) mod 65536. addr_o = {second byte, first byte}.
- R8: Mode 11 (pre-indexed) takes P = {8'h00, (op_lo_i + x_i) mod 256}. It reads at P and then at P+1, so the high byte comes from 0x0100 when P is 0x00FF. addr_o = {second, first}. y_i has no effect.
- R9: Mode 12 (post-indexed) takes P = {8'h00, op_lo_i}. It reads at P and P+1, then adds y_i to {second, first} modulo 65536. x_i has no effect.
- R10: A request is accepted on a clock edge where req_i is 1 and busy_o is 0. Non-pointer modes raise done_o in the first cycle after that edge. Pointer modes (10 to 12) hold busy_o high for three cycles, with rd_en_o high in the first two of them. done_o then rises in the fourth cycle.
- R11: req_i has no effect while busy_o is 1.
- R12: done_o lasts one cycle per accepted request. kind_o, value_o and addr_o hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing-mode code |
| op_lo_i | input | 8 | First byte after the opcode |
| op_hi_i | input | 8 | Second byte after the opcode |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| busy_o | output | 1 | Pointer fetch in progress |
| done_o | output | 1 | Result valid, one-cycle pulse |
| kind_o | output | 2 | 0 none, 1 immediate, 2 relative, 3 address |
| value_o | output | 8 | Immediate byte or branch offset |
| addr_o | output | 16 | Effective address |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | 16 | Memory read address |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |

## Verification
The sequencer's state is visible at the ports through rd_en_o, rd_addr_o and the cycle in which done_o rises. A stuck or skipped state therefore shows up within four cycles of the request, as a wrong read count or wrong latency. If the low pointer byte is captured in the wrong cycle, or the index is applied on the wrong side of the fetch, addr_o is wrong. The bench places a memory whose content is a known function of its address behind the read port, so each of these faults gives a distinct address. Page-zero wrap and 16-bit wrap each get a vector that crosses the boundary.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int DW = 8;
  localparam int AW = 16;

  typedef enum logic [3:0] {
    M_ACC = 4'd0, M_IMP = 4'd1, M_IMM = 4'd2, M_ZP = 4'd3, M_ZPX = 4'd4,
    M_ZPY = 4'd5, M_REL = 4'd6, M_ABS = 4'd7, M_ABSX = 4'd8, M_ABSY = 4'd9,
    M_IND = 4'd10, M_PREX = 4'd11, M_POSTY = 4'd12
  } mode_e;

  typedef enum logic [1:0] {K_NONE = 2'd0, K_IMM = 2'd1, K_REL = 2'd2, K_ADDR = 2'd3} kind_e;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_FIN = 2'd3} fsm_e;
endpackage

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
  import ea_pkg::*;
#(
  parameter int DW = ea_pkg::DW,
  parameter int AW = ea_pkg::AW
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [1:0]    kind_o,
  output logic [DW-1:0] value_o,
  output logic [AW-1:0] addr_o,
  output logic          is_zp_o,
  output logic          is_ptr_o,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] off_o
);
  localparam int PADW = AW - DW;

  logic [DW-1:0] zp_x, zp_y;
  logic [AW-1:0] abs_a, idx_x, idx_y;

  assign zp_x  = lo_i + x_i;
  assign zp_y  = lo_i + y_i;
  assign abs_a = {hi_i, lo_i};
  assign idx_x = {{PADW{1'b0}}, x_i};
  assign idx_y = {{PADW{1'b0}}, y_i};

  always_comb begin
    kind_o   = K_NONE;
    value_o  = '0;
    addr_o   = '0;
    is_zp_o  = 1'b0;
    is_ptr_o = 1'b0;
    ptr_o    = '0;
    off_o    = '0;
    case (mode_i)
      M_IMM:  begin kind_o = K_IMM; value_o = lo_i; end
      M_REL:  begin kind_o = K_REL; value_o = lo_i; end
      M_ZP:   begin kind_o = K_ADDR; addr_o = {{PADW{1'b0}}, lo_i}; is_zp_o = 1'b1; end
      M_ZPX:  begin kind_o = K_ADDR; addr_o = {{PADW{1'b0}}, zp_x}; is_zp_o = 1'b1; end
      M_ZPY:  begin kind_o = K_ADDR; addr_o = {{PADW{1'b0}}, zp_y}; is_zp_o = 1'b1; end
      M_ABS:  begin kind_o = K_ADDR; addr_o = abs_a; end
      M_ABSX: begin kind_o = K_ADDR; addr_o = abs_a + idx_x; end
      M_ABSY: begin kind_o = K_ADDR; addr_o = abs_a + idx_y; end
      M_IND:  begin kind_o = K_ADDR; is_ptr_o = 1'b1; ptr_o = abs_a; end
      M_PREX: begin kind_o = K_ADDR; is_ptr_o = 1'b1; ptr_o = {{PADW{1'b0}}, zp_x}; end
      M_POSTY: begin
        kind_o = K_ADDR; is_ptr_o = 1'b1;
        ptr_o  = {{PADW{1'b0}}, lo_i};
        off_o  = idx_y;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_pkg::*;
#(
  parameter int DW = ea_pkg::DW,
  parameter int AW = ea_pkg::AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] off_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic [AW-1:0] ea_o
);
  fsm_e          state_q;
  logic [AW-1:0] ptr_q, off_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      off_q   <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          ptr_q   <= ptr_i;
          off_q   <= off_i;
          state_q <= S_LO;
        end
        S_LO:  state_q <= S_HI;
        S_HI: begin
          lo_q    <= rd_data_i;
          state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign rd_en_o   = (state_q == S_LO) || (state_q == S_HI);
  // pointer high byte sits at the next byte of the full address space
  assign rd_addr_o = (state_q == S_HI) ? ptr_q + 1'b1 : ptr_q;
  assign fin_o     = (state_q == S_FIN);
  assign ea_o      = {rd_data_i, lo_q} + off_q;

  a_r7_hi_read_follows_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HI) |-> (rd_addr_o == AW'($past(rd_addr_o) + 1'b1)));

  a_r10_read_only_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DW = ea_pkg::DW,
  parameter int AW = ea_pkg::AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    kind_o,
  output logic [DW-1:0] value_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  logic [1:0]    c_kind;
  logic [DW-1:0] c_value;
  logic [AW-1:0] c_addr, c_ptr, c_off, f_ea;
  logic          c_zp, c_ptr_mode, f_busy, f_fin, accept;
  logic          done_q, zp_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] value_q;
  logic [AW-1:0] addr_q;

  ea_direct_calc #(.DW(DW), .AW(AW)) u_calc (
    .mode_i(mode_i), .lo_i(op_lo_i), .hi_i(op_hi_i), .x_i(x_i), .y_i(y_i),
    .kind_o(c_kind), .value_o(c_value), .addr_o(c_addr), .is_zp_o(c_zp),
    .is_ptr_o(c_ptr_mode), .ptr_o(c_ptr), .off_o(c_off)
  );

  assign accept = req_i && !f_busy;

  ea_ptr_fetch #(.DW(DW), .AW(AW)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept && c_ptr_mode),
    .ptr_i(c_ptr), .off_i(c_off), .rd_data_i(rd_data_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .busy_o(f_busy),
    .fin_o(f_fin), .ea_o(f_ea)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      zp_q    <= 1'b0;
      kind_q  <= K_NONE;
      value_q <= '0;
      addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (f_fin) begin
        done_q  <= 1'b1;
        zp_q    <= 1'b0;
        kind_q  <= K_ADDR;
        value_q <= '0;
        addr_q  <= f_ea;
      end else if (accept && !c_ptr_mode) begin
        done_q  <= 1'b1;
        zp_q    <= c_zp;
        kind_q  <= c_kind;
        value_q <= c_value;
        addr_q  <= c_addr;
      end
    end
  end

  assign busy_o  = f_busy;
  assign done_o  = done_q;
  assign kind_o  = kind_q;
  assign value_o = value_q;
  assign addr_o  = addr_q;

  a_r5_zero_page_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zp_q) |-> (addr_o[AW-1:DW] == '0));

  a_r10_no_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  a_r12_hold_between_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(f_fin) && !$past(accept)) |-> $stable(addr_o));
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, x_i = '0, y_i = '0;
  logic        busy_o, done_o, rd_en_o;
  logic [1:0]  kind_o;
  logic [7:0]  value_o;
  logic [15:0] addr_o, rd_addr_o;
  logic [7:0]  rd_data_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // memory model: byte at A is A[7:0] ^ A[15:8], one cycle latency
  always @(posedge clk) if (rd_en_o) rd_data_i <= rd_addr_o[7:0] ^ rd_addr_o[15:8];

  ea_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .mode_i(mode_i),
    .op_lo_i(op_lo_i), .op_hi_i(op_hi_i), .x_i(x_i), .y_i(y_i),
    .busy_o(busy_o), .done_o(done_o), .kind_o(kind_o), .value_o(value_o),
    .addr_o(addr_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );

  localparam int NV = 20;
  // {mode, lo, hi, x, y, kind, value, addr}
  localparam logic [61:0] VEC [NV] = '{
    {4'd0,  8'h12, 8'h34, 8'h00, 8'h00, 2'd0, 8'h00, 16'h0000},
    {4'd1,  8'hAA, 8'hBB, 8'h11, 8'h22, 2'd0, 8'h00, 16'h0000},
    {4'd2,  8'h9C, 8'h00, 8'h00, 8'h00, 2'd1, 8'h9C, 16'h0000},
    {4'd6,  8'hF0, 8'h00, 8'h00, 8'h00, 2'd2, 8'hF0, 16'h0000},
    {4'd3,  8'h80, 8'h44, 8'h33, 8'h00, 2'd3, 8'h00, 16'h0080},
    {4'd4,  8'hF0, 8'h44, 8'h20, 8'h00, 2'd3, 8'h00, 16'h0010},
    {4'd5,  8'h10, 8'h00, 8'h00, 8'h05, 2'd3, 8'h00, 16'h0015},
    {4'd7,  8'h34, 8'h12, 8'h00, 8'h00, 2'd3, 8'h00, 16'h1234},
    {4'd8,  8'hF0, 8'h12, 8'h20, 8'h00, 2'd3, 8'h00, 16'h1310},
    {4'd9,  8'hF0, 8'hFF, 8'h00, 8'h20, 2'd3, 8'h00, 16'h0010},
    {4'd10, 8'h00, 8'h30, 8'h00, 8'h00, 2'd3, 8'h00, 16'h3130},
    {4'd10, 8'hFF, 8'hFF, 8'h00, 8'h00, 2'd3, 8'h00, 16'h0000},
    {4'd11, 8'h10, 8'h00, 8'h05, 8'h99, 2'd3, 8'h00, 16'h1615},
    {4'd11, 8'hF0, 8'h00, 8'h0F, 8'h00, 2'd3, 8'h00, 16'h01FF},
    {4'd11, 8'hF8, 8'h00, 8'h10, 8'h00, 2'd3, 8'h00, 16'h0908},
    {4'd12, 8'h20, 8'h00, 8'h77, 8'h10, 2'd3, 8'h00, 16'h2130},
    {4'd12, 8'h40, 8'h00, 8'h00, 8'hFF, 2'd3, 8'h00, 16'h423F},
    {4'd12, 8'hFE, 8'h00, 8'h00, 8'h05, 2'd3, 8'h00, 16'h0003},
    {4'd13, 8'h55, 8'h66, 8'h00, 8'h00, 2'd0, 8'h00, 16'h0000},
    {4'd15, 8'h55, 8'h66, 8'h00, 8'h00, 2'd0, 8'h00, 16'h0000}
  };

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd2: return "R3";
      4'd6: return "R4";
      4'd3, 4'd4, 4'd5: return "R5";
      4'd7, 4'd8, 4'd9: return "R6";
      4'd10: return "R7";
      4'd11: return "R8";
      4'd12: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] m, input logic [7:0] lo, hi, x, y);
    mode_i = m; op_lo_i = lo; op_hi_i = hi; x_i = x; y_i = y; req_i = 1'b1;
  endtask

  task automatic run_vec(input int i);
    logic [61:0] v;
    int lat, rds, exp_lat, exp_rds;
    string rq;
    v = VEC[i];
    rq = req_of(v[61:58]);
    exp_lat = (v[61:58] >= 4'd10 && v[61:58] <= 4'd12) ? 4 : 1;
    exp_rds = (exp_lat == 4) ? 2 : 0;
    drive(v[61:58], v[57:50], v[49:42], v[41:34], v[33:26]);
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    lat = 0; rds = 0;
    for (int k = 1; k <= 8; k++) begin
      if (rd_en_o) rds++;
      if (done_o) begin lat = k; break; end
      @(negedge clk);
    end
    chk("R10", "latency", lat, exp_lat);
    chk("R10", "reads", rds, exp_rds);
    chk(rq, "kind", {30'd0, kind_o}, {30'd0, v[25:24]});
    chk(rq, "value", {24'd0, value_o}, {24'd0, v[23:16]});
    chk(rq, "addr", {16'd0, addr_o}, {16'd0, v[15:0]});
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", {31'd0, busy_o}, 0);
    chk("R1", "done in reset", {31'd0, done_o}, 0);
    chk("R1", "rd_en in reset", {31'd0, rd_en_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", {31'd0, done_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11: request while busy is ignored; R12 single pulse and hold
    drive(4'd11, 8'h10, 8'h00, 8'h05, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "busy after pointer accept", {31'd0, busy_o}, 1);
    drive(4'd2, 8'hAB, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    req_i = 1'b0;
    chk("R11", "done after ignored req", {31'd0, done_o}, 1);
    chk("R11", "kind after ignored req", {30'd0, kind_o}, 3);
    chk("R11", "addr after ignored req", {16'd0, addr_o}, 32'h1615);
    @(negedge clk);
    chk("R11", "no second done", {31'd0, done_o}, 0);
    chk("R12", "addr held", {16'd0, addr_o}, 32'h1615);
    @(negedge clk);
    chk("R12", "kind held", {30'd0, kind_o}, 3);

    // R1: reset during pointer fetch
    drive(4'd10, 8'h00, 8'h30, 8'h00, 8'h00);
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1", "busy after mid reset", {31'd0, busy_o}, 0);
    chk("R1", "rd_en after mid reset", {31'd0, rd_en_o}, 0);
    chk("R1", "done after mid reset", {31'd0, done_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    run_vec(7);
    run_vec(16);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule